// File: doc/BRIEF.md
# Configuration RAM Index/Data Port Pair

This block places two indexed byte-wide ports in front of two 128-byte banks of battery-backed configuration storage. For each bank, software first writes a location number to an index port. It then reads or writes that location through the paired data port. The primary bank uses I/O addresses 0x70 (index) and 0x71 (data). The secondary bank uses 0x72 (index) and 0x73 (data). The block decodes an 8-bit I/O address on a single-cycle strobe bus.

Bit 7 of a byte written to the primary index port is not part of the address. It is captured as the system NMI mask. The block's NMI output is the incoming request gated by the inverse of that mask. Locations 0x00–0x0D are plain storage here, and no timekeeping runs behind them. Reset parks both indices on 0x0D and sets the mask. Reset leaves the storage contents untouched.

Top module: `cfg_nvram_ports`

## Requirements
- R1: After reset, a read of address 0x70 returns 0x8D (mask set, primary index 0x0D), a read of 0x72 returns 0x0D, and nmi_o is 0 whatever nmi_req_i does.
- R2: A write to 0x70 stores bits 6:0 as the primary index and bit 7 as the NMI mask. A read of 0x70 returns {mask, index}.
- R3: nmi_o equals nmi_req_i AND NOT mask, combinationally.
- R4: A write to 0x71 stores the byte at the primary index. A read of 0x71 returns the stored byte in the same cycle (combinational read data).
- R5: A write to 0x72 stores bits 6:0 as the secondary index and leaves the NMI mask unchanged. A read of 0x72 returns {0, secondary index}.
- R6: A write to 0x73 stores the byte at the secondary index of the secondary bank. The primary bank is independent: equal indices in the two banks hold separate bytes.
- R7: Data-port reads and writes never change either index, so repeated accesses hit the same location.
- R8: Reset does not clear the storage: bytes written before a reset read back unchanged after it.
- R9: Addresses other than 0x70–0x73 neither change state nor drive read data (rdata_o reads 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 8 | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid while io_rd_i is high |
| nmi_req_i | input | 1 | Incoming NMI request |
| nmi_o | output | 1 | Gated NMI to the CPU |

## Verification
The assertions assume that io_wr_i and io_rd_i are never high in the same cycle. They also assume the address is stable while a strobe is high. The bench drives each access as a single strobe cycle, with address and data set away from the clock edge and one idle cycle between accesses, so it stays within both assumptions. nmi_req_i is toggled only when no write to the mask is pending. This keeps the gating check free of races with mask updates.

// File: rtl/cfg_nvram_pkg.sv
package cfg_nvram_pkg;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned N_BANKS = 2;
  localparam logic [IDX_W-1:0] IDX_RST = 7'h0D;

  typedef enum logic [1:0] {
    PORT_NONE,
    PORT_INDEX,
    PORT_DATA
  } port_kind_e;

  typedef struct packed {
    port_kind_e kind;
    logic       bank;
  } port_sel_t;
endpackage

// File: rtl/cfg_nvram_decode.sv
module cfg_nvram_decode
  import cfg_nvram_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h70
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_t         sel_o
);
  logic [ADDR_W-1:0] off;
  assign off = addr_i - BASE_ADDR;

  always_comb begin
    sel_o.kind = PORT_NONE;
    sel_o.bank = off[1];
    if (off[ADDR_W-1:2] == '0) sel_o.kind = off[0] ? PORT_DATA : PORT_INDEX;
  end
endmodule

// File: rtl/cfg_nvram_bank.sv
module cfg_nvram_bank
  import cfg_nvram_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter bit          HAS_MASK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx_q;
  logic              mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= IDX_RST;
    else if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  generate
    if (HAS_MASK) begin : g_mask
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q <= 1'b1;
        else if (idx_we_i) mask_q <= wdata_i[DATA_W-1];
      end
    end else begin : g_nomask
      assign mask_q = 1'b0;
    end
  endgenerate

  // storage is battery-backed: no reset
  always_ff @(posedge clk_i) begin
    if (dat_we_i) mem_q[idx_q] <= wdata_i;
  end

  assign idx_o   = idx_q;
  assign mask_o  = mask_q;
  assign rdata_o = mem_q[idx_q];

  assert_idx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_we_i |=> $stable(idx_q));
  assert_idx_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i |=> idx_q == $past(wdata_i[IDX_W-1:0]));
  assert_mem_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && !idx_we_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/cfg_nvram_ports.sv
module cfg_nvram_ports
  import cfg_nvram_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h70,
  parameter int unsigned       DEPTH     = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic              nmi_req_i,
  output logic              nmi_o
);
  port_sel_t         sel;
  logic [IDX_W-1:0]  idx   [N_BANKS];
  logic              mask  [N_BANKS];
  logic [DATA_W-1:0] rdata [N_BANKS];

  cfg_nvram_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (.addr_i(io_addr_i), .sel_o(sel));

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    cfg_nvram_bank #(.DEPTH(DEPTH), .HAS_MASK(b == 0)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .idx_we_i(io_wr_i && sel.kind == PORT_INDEX && sel.bank == b[0]),
      .dat_we_i(io_wr_i && sel.kind == PORT_DATA  && sel.bank == b[0]),
      .wdata_i (io_wdata_i),
      .idx_o   (idx[b]),
      .mask_o  (mask[b]),
      .rdata_o (rdata[b])
    );
  end

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      unique case (sel.kind)
        PORT_INDEX: io_rdata_o = {mask[sel.bank], idx[sel.bank]};
        PORT_DATA:  io_rdata_o = rdata[sel.bank];
        default:    io_rdata_o = '0;
      endcase
    end
  end

  assign nmi_o = nmi_req_i & ~mask[0];

  assert_no_rdwr_clash_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_rd_i));
  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && io_addr_i == BASE_ADDR |=> mask[0] == $past(io_wdata_i[DATA_W-1]));
  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == BASE_ADDR) |=> $stable(mask[0]));
  assert_nmi_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask[0] |-> !nmi_o);
  assert_unmapped_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && sel.kind == PORT_NONE |-> io_rdata_o == '0);
endmodule

// File: tb/cfg_nvram_ports_tb.sv
module cfg_nvram_ports_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr = 1'b0, rd = 1'b0, nmi_req = 1'b0;
  logic [7:0] rdata;
  logic       nmi;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cfg_nvram_ports u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .nmi_req_i(nmi_req), .nmi_o(nmi));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    io_rd(8'h70, v); chk("R1 primary index", v, 8'h8D);
    io_rd(8'h72, v); chk("R1 secondary index", v, 8'h0D);
    nmi_req = 1'b1; #1 chk("R1 nmi masked", {7'd0, nmi}, 8'h00);
    nmi_req = 1'b0;
  endtask

  task automatic t_index_mask();
    logic [7:0] v;
    io_wr(8'h70, 8'h25); io_rd(8'h70, v); chk("R2 index unmasked", v, 8'h25);
    nmi_req = 1'b1; #1 chk("R3 nmi passes", {7'd0, nmi}, 8'h01);
    nmi_req = 1'b0; #1 chk("R3 nmi idle", {7'd0, nmi}, 8'h00);
    io_wr(8'h70, 8'hBF); io_rd(8'h70, v); chk("R2 index masked", v, 8'hBF);
    nmi_req = 1'b1; #1 chk("R3 nmi blocked", {7'd0, nmi}, 8'h00);
    nmi_req = 1'b0;
  endtask

  task automatic t_second_bank();
    logic [7:0] v;
    io_wr(8'h70, 8'h10);
    io_wr(8'h72, 8'hC4); io_rd(8'h72, v); chk("R5 secondary index", v, 8'h44);
    io_rd(8'h70, v); chk("R5 mask untouched", v, 8'h10);
    io_wr(8'h70, 8'h44); io_wr(8'h71, 8'hA1);
    io_wr(8'h73, 8'h5E);
    io_rd(8'h71, v); chk("R6 primary kept", v, 8'hA1);
    io_rd(8'h73, v); chk("R6 secondary", v, 8'h5E);
  endtask

  task automatic t_data_repeat();
    logic [7:0] v;
    io_wr(8'h70, 8'h7F); io_wr(8'h71, 8'h3C);
    io_rd(8'h71, v); chk("R4 data read", v, 8'h3C);
    io_rd(8'h71, v); chk("R7 repeat read", v, 8'h3C);
    io_wr(8'h71, 8'h99); io_rd(8'h71, v); chk("R7 overwrite same loc", v, 8'h99);
    io_rd(8'h70, v); chk("R7 index held", v, 8'h7F);
    io_wr(8'h70, 8'h0E); io_wr(8'h71, 8'h11);
    io_wr(8'h70, 8'h7F); io_rd(8'h71, v); chk("R4 other loc intact", v, 8'h99);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    io_wr(8'h74, 8'hFF); io_wr(8'h6F, 8'h80); io_wr(8'hF1, 8'h00);
    io_rd(8'h70, v); chk("R9 index unchanged", v, 8'h7F);
    io_rd(8'h71, v); chk("R9 data unchanged", v, 8'h99);
    io_rd(8'h74, v); chk("R9 unmapped read", v, 8'h00);
  endtask

  task automatic t_retention();
    logic [7:0] v;
    do_reset();
    io_rd(8'h70, v); chk("R1 index after reset", v, 8'h8D);
    io_wr(8'h70, 8'h7F); io_rd(8'h71, v); chk("R8 primary retained", v, 8'h99);
    io_wr(8'h72, 8'h44); io_rd(8'h73, v); chk("R8 secondary retained", v, 8'h5E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_index_mask();
    t_second_bank();
    t_data_repeat();
    t_unmapped();
    t_retention();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule